// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 40-bit Accumulator

This block multiplies two 16-bit operands and either loads the product into a 40-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator. A new operation can be issued on every clock. Each operand is treated as signed or unsigned according to its own bit in a two-bit mode field. The product is first extended to 17 bits per operand and then sign-extended to the accumulator width. An optional rounding step adds one half of a middle-word unit to the new value.

The accumulator is seen from outside as three result fields: a low word, a middle word and an 8-bit extension. An overflow flag reports when the value no longer fits in 32 signed bits. An idle opcode leaves every output unchanged. The control is a small datapath with no state machine: one register stage holds the accumulator and the flag.

Top module: `mac40_unit`

## Requirements
- R1: While `rst_n` is low, all three result fields and `ovf` are zero.
- R2: Opcode 2'b00 (multiply) loads the accumulator with the product, sign-extended to 40 bits. The result is visible one clock after the operands are presented.
- R3: In the mode field, bit 1 marks `opa` as signed and bit 0 marks `opb` as signed. So 2'b11 means both signed, 2'b10 means signed times unsigned, 2'b01 means unsigned times signed, and 2'b00 means both unsigned.
- R4: Opcode 2'b01 (accumulate) adds the product to the current accumulator value.
- R5: Opcode 2'b10 (subtract) subtracts the product from the current accumulator value.
- R6: Opcode 2'b11 (idle) leaves all result fields and `ovf` unchanged.
- R7: When `round_en` is high on an active opcode, 0x8000 is added to the 40-bit result after the multiply, add or subtract.
- R8: `res_lo` shows accumulator bits 15..0, `res_mid` shows bits 31..16 and `res_ext` shows bits 39..32.
- R9: `ovf` is high exactly when accumulator bits 39..31 are not all equal. It is updated together with the result.
- R10: All arithmetic wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 16 | X operand |
| opb | input | 16 | Y operand |
| opcode | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 idle |
| sign_mode | input | 2 | Bit 1: X signed; bit 0: Y signed |
| round_en | input | 1 | Add 0x8000 to the result |
| res_lo | output | 16 | Accumulator bits 15..0 |
| res_mid | output | 16 | Accumulator bits 31..16 |
| res_ext | output | 8 | Accumulator bits 39..32 |
| ovf | output | 1 | Result exceeds 32 signed bits |

## Verification
Every result field and the overflow flag are due one rising edge after the operation is presented, and all of them move on that same edge. The bench drives each operation on a falling edge. It compares all four outputs against its own 40-bit model on the next falling edge, and only then drives the next operation. This means each check sees exactly one accumulator update. An idle operation is checked the same way: the bench expects the previous values at that sample point.

// File: rtl/mac40_pkg.sv
`timescale 1ns/1ps
package mac40_pkg;

    // Operation select; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MAC  = 2'b01,
        OP_MSUB = 2'b10,
        OP_IDLE = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac40_opnd_ext.sv
`timescale 1ns/1ps
// Widens an operand by one bit, using either sign or zero fill.
module mac40_opnd_ext #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0] din,
    input  logic            is_signed,
    output logic [IN_W:0]   dout
);

    always_comb begin
        dout = {is_signed & din[IN_W-1], din};
    end

endmodule

// File: rtl/mac40_mult.sv
`timescale 1ns/1ps
// Signed multiply of two widened operands, giving the full-width product.
module mac40_mult #(
    parameter int IN_W = 17,
    localparam int OUT_W = 2 * IN_W
) (
    input  logic [IN_W-1:0]  xa,
    input  logic [IN_W-1:0]  ya,
    output logic [OUT_W-1:0] prod
);

    always_comb begin
        prod = OUT_W'($signed(xa) * $signed(ya));
    end

endmodule

// File: rtl/mac40_accum.sv
`timescale 1ns/1ps
// Accumulator register with load, add and subtract, optional rounding, and an overflow flag.
module mac40_accum
    import mac40_pkg::*;
#(
    parameter int PROD_W  = 34,
    parameter int ACC_W   = 40,
    parameter int RND_POS = 15,
    parameter int OVF_LSB = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mac_op_e          op,
    input  logic             rnd,
    input  logic [PROD_W-1:0] prod,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_q
);

    localparam int EXT_BITS = ACC_W - PROD_W;
    localparam int GUARD_W  = ACC_W - OVF_LSB;
    localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << RND_POS;

    logic [ACC_W-1:0]   prod_wide;
    logic [ACC_W-1:0]   pre_rnd;
    logic [ACC_W-1:0]   acc_d;
    logic [GUARD_W-1:0] guard;
    logic               ovf_d;

    always_comb begin
        prod_wide = {{EXT_BITS{prod[PROD_W-1]}}, prod};
        unique case (op)
            OP_MUL:  pre_rnd = prod_wide;
            OP_MAC:  pre_rnd = acc_q + prod_wide;
            OP_MSUB: pre_rnd = acc_q - prod_wide;
            OP_IDLE: pre_rnd = acc_q;
        endcase
        acc_d = rnd ? (pre_rnd + RND_K) : pre_rnd;
        guard = acc_d[ACC_W-1:OVF_LSB];
        ovf_d = !((guard == '0) || (guard == '1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (op != OP_IDLE) begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
        end
    end

endmodule

// File: rtl/mac40_unit.sv
`timescale 1ns/1ps
// Top: operand widening, multiplier, and the accumulator split into three fields.
module mac40_unit
    import mac40_pkg::*;
#(
    parameter int OPND_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPND_W-1:0] opa,
    input  logic [OPND_W-1:0] opb,
    input  logic [1:0]        opcode,
    input  logic [1:0]        sign_mode,
    input  logic              round_en,
    output logic [OPND_W-1:0] res_lo,
    output logic [OPND_W-1:0] res_mid,
    output logic [EXT_W-1:0]  res_ext,
    output logic              ovf
);

    localparam int WIDE_W = OPND_W + 1;
    localparam int PROD_W = 2 * WIDE_W;
    localparam int ACC_W  = 2 * OPND_W + EXT_W;

    logic [OPND_W-1:0] opnd_raw [2];
    logic [WIDE_W-1:0] opnd_wide [2];
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;
    mac_op_e           op;

    always_comb begin
        opnd_raw[0] = opa;
        opnd_raw[1] = opb;
        op          = mac_op_e'(opcode);
    end

    // Index 0 is X (mode bit 1); index 1 is Y (mode bit 0).
    for (genvar g = 0; g < 2; g++) begin : g_ext
        mac40_opnd_ext #(.IN_W(OPND_W)) ext_i (
            .din       (opnd_raw[g]),
            .is_signed (sign_mode[1-g]),
            .dout      (opnd_wide[g])
        );
    end

    mac40_mult #(.IN_W(WIDE_W)) mult_i (
        .xa   (opnd_wide[0]),
        .ya   (opnd_wide[1]),
        .prod (prod)
    );

    mac40_accum #(
        .PROD_W  (PROD_W),
        .ACC_W   (ACC_W),
        .RND_POS (OPND_W - 1),
        .OVF_LSB (2 * OPND_W - 1)
    ) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .rnd   (round_en),
        .prod  (prod),
        .acc_q (acc),
        .ovf_q (ovf)
    );

    always_comb begin
        res_lo  = acc[OPND_W-1:0];
        res_mid = acc[2*OPND_W-1:OPND_W];
        res_ext = acc[ACC_W-1:2*OPND_W];
    end

endmodule

// File: rtl/mac40_unit_chk.sv
`timescale 1ns/1ps
module mac40_unit_chk #(
    parameter int OPND_W = 16,
    parameter int EXT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPND_W-1:0] opa,
    input logic [OPND_W-1:0] opb,
    input logic [1:0]        opcode,
    input logic              round_en,
    input logic [OPND_W-1:0] res_lo,
    input logic [OPND_W-1:0] res_mid,
    input logic [EXT_W-1:0]  res_ext,
    input logic              ovf
);

    // R1: reset holds every output at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (res_lo == '0 && res_mid == '0 && res_ext == '0 && !ovf));

    // R6: the idle opcode freezes the outputs
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == 2'b11 |=> ($stable(res_lo) && $stable(res_mid) && $stable(res_ext) && $stable(ovf)));

    // R2: a multiply by zero without rounding clears the accumulator
    a_r2_mul_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b00 && !round_en && (opa == '0 || opb == '0))
        |=> (res_lo == '0 && res_mid == '0 && res_ext == '0 && !ovf));

    // R7: rounding a zero product leaves only the half-unit in the low word
    a_r7_round_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b00 && round_en && opa == '0)
        |=> (res_lo == 16'h8000 && res_mid == '0 && res_ext == '0 && !ovf));

    // R9: the flag matches the guard bits of the output fields
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == (res_ext != {EXT_W{res_mid[OPND_W-1]}}));

endmodule

bind mac40_unit mac40_unit_chk #(.OPND_W(OPND_W), .EXT_W(EXT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .opa      (opa),
    .opb      (opb),
    .opcode   (opcode),
    .round_en (round_en),
    .res_lo   (res_lo),
    .res_mid  (res_mid),
    .res_ext  (res_ext),
    .ovf      (ovf)
);

// File: tb/mac40_unit_tb_top.sv
`timescale 1ns/1ps
module mac40_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] opa, opb;
    logic [1:0]  opcode, sign_mode;
    logic        round_en;
    logic [15:0] res_lo, res_mid;
    logic [7:0]  res_ext;
    logic        ovf;

    int          checks = 0;
    int          errors = 0;
    logic [39:0] model = '0;
    logic        model_ovf = 1'b0;

    always #4 clk = ~clk;

    mac40_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .opcode(opcode),
        .sign_mode(sign_mode), .round_en(round_en),
        .res_lo(res_lo), .res_mid(res_mid), .res_ext(res_ext), .ovf(ovf)
    );

    function automatic logic [39:0] ref_step(logic [39:0] acc, logic [15:0] a, logic [15:0] b,
                                             logic [1:0] op, logic [1:0] md, logic rnd);
        logic [39:0] xe, ye, p, r;
        xe = {{24{md[1] & a[15]}}, a};
        ye = {{24{md[0] & b[15]}}, b};
        p  = xe * ye;
        case (op)
            2'b00:   r = p;
            2'b01:   r = acc + p;
            2'b10:   r = acc - p;
            default: r = acc;
        endcase
        if (rnd && op != 2'b11) r = r + 40'h8000;
        return r;
    endfunction

    function automatic logic ref_ovf(logic [39:0] v);
        return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
    endfunction

    task automatic compare(string tag);
        logic [39:0] got;
        got = {res_ext, res_mid, res_lo};
        checks++;
        if (got !== model || ovf !== model_ovf) begin
            errors++;
            $display("FAIL %s: got acc=%010h ovf=%0b expected acc=%010h ovf=%0b",
                     tag, got, ovf, model, model_ovf);
        end
    endtask

    // Called at a falling edge; drives one operation and checks it at the next falling edge.
    task automatic issue(logic [1:0] op, logic [15:0] a, logic [15:0] b,
                         logic [1:0] md, logic rnd, string tag);
        opcode = op; opa = a; opb = b; sign_mode = md; round_en = rnd;
        if (op != 2'b11) begin
            model     = ref_step(model, a, b, op, md, rnd);
            model_ovf = ref_ovf(model);
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; opa = '0; opb = '0; opcode = 2'b11; sign_mode = '0; round_en = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R8 / R9: mode corners on 0xFFFF x 0xFFFF
        issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b00, 1'b0, "R3 UU (R9 ovf set, R8 fields)");
        issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b11, 1'b0, "R3 SS");
        issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b10, 1'b0, "R3 SU");
        issue(2'b00, 16'hFFFF, 16'hFFFF, 2'b01, 1'b0, "R3 US");
        issue(2'b00, 16'h8000, 16'h8000, 2'b11, 1'b0, "R2 most negative squared");
        // R7 rounding
        issue(2'b00, 16'h0001, 16'h7FFF, 2'b11, 1'b1, "R7 round mul");
        issue(2'b01, 16'h0001, 16'h8000, 2'b00, 1'b1, "R7 round mac carry");
        // R4 / R5 basic
        issue(2'b01, 16'h1234, 16'h0010, 2'b11, 1'b0, "R4 accumulate");
        issue(2'b10, 16'h1234, 16'h0010, 2'b11, 1'b0, "R5 subtract");
        issue(2'b11, 16'hAAAA, 16'h5555, 2'b00, 1'b1, "R6 idle hold");
        // R10: below zero, then wrap through the top of the accumulator
        issue(2'b00, 16'h0000, 16'h0000, 2'b11, 1'b0, "R2 clear");
        issue(2'b10, 16'h0001, 16'h0001, 2'b11, 1'b0, "R10 negative wrap");
        for (int i = 0; i < 520; i++)
            issue(2'b01, 16'h8000, 16'h8000, 2'b11, 1'b0, "R10 R9 accumulate to wrap");
        for (int i = 0; i < 300; i++)
            issue(2'b10, 16'h8000, 16'h8000, 2'b11, 1'b0, "R10 R5 subtract run");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  op;
            logic [15:0] a, b;
            logic        rnd;
            string       tag;
            op  = 2'($urandom_range(0, 3));
            a   = ($urandom_range(0, 7) == 0) ? 16'h8000 : 16'($urandom);
            b   = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom);
            rnd = ($urandom_range(0, 3) == 0);
            case (op)
                2'b00:   tag = "R2 random mul";
                2'b01:   tag = "R4 random mac";
                2'b10:   tag = "R5 random msub";
                default: tag = "R6 random idle";
            endcase
            if (rnd && op != 2'b11) tag = {tag, " R7"};
            issue(op, a, b, 2'($urandom_range(0, 3)), rnd, tag);
        end

        opcode = 2'b11;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule